// File: doc/BRIEF.md
# Atomic Sequence Ownership Gate

This block sits in front of a shared memory sequencer and decides, request by request, whether a processor may proceed. Once some processor has an accepted read-modify-write read in flight, it becomes the owner of the gate. Every other processor is then refused until the owner's sequence is over. The block keeps an owner register and a nesting counter. Nested read-modify-write reads from the owner deepen the nesting. Each completed read-modify-write write unwinds one level. Any other request type from the owner abandons the sequence at once.

A request is a valid strobe, a processor ID and a 3-bit kind code. The ready answer is combinational from the current state and the presented ID. The state moves only on a clock edge where the request is valid, ready and not marked as a query-only probe. Write completions come in on a separate port with their own processor ID. An error pulse flags a completion that does not fit the state, and a nesting overflow.

Top module: `atomic_seq_gate`

## Requirements
- R1: After reset the owner output holds the free marker (parameter, default 200), the nesting count is 0 and the error output is low.
- R2: `req_ready` is low exactly when an owner exists and `req_id` differs from it. It depends only on the current state and `req_id`, and is high whenever there is no owner.
- R3: An accepted request of kind 2 (read-modify-write read) with no current owner makes the requester the owner, with a count of 1, at the next edge.
- R4: An accepted kind-2 request from the current owner raises the count by one and keeps the owner.
- R5: An accepted request from the owner whose kind is neither 2 nor 3 sets the owner back to the free marker and the count to 0. This overrides a completion in the same cycle.
- R6: A valid completion from the owner while the count is above zero lowers the count by one. When the count reaches 0, the owner returns to the free marker.
- R7: A completion from a processor other than the owner, or one that arrives while the count is 0, leaves the owner and count unchanged and raises `err_pulse` for the following cycle only.
- R8: While `req_dont_set` is high, a request changes neither owner nor count, but `req_ready` is still reported.
- R9: The count saturates at 15. An accepted kind-2 request at 15 without a same-cycle valid completion keeps the count at 15 and raises `err_pulse` in the next cycle.
- R10: An accepted kind-3 request (read-modify-write write) from the owner changes no state. A refused request changes no state.
- R11: An accepted kind-2 request from the owner and a valid completion from the owner in the same cycle leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_id | input | 8 | Processor ID of the request |
| req_type | input | 3 | Request kind: 0 load, 1 store, 2 RMW read, 3 RMW write, 4 fetch, 5-7 other |
| req_dont_set | input | 1 | Query only: report ready without updating state |
| req_ready | output | 1 | Request may proceed |
| cmpl_valid | input | 1 | A read-modify-write write has completed |
| cmpl_id | input | 8 | Processor ID of the completion |
| owner_id | output | 8 | Current owner, or the free marker |
| nest_count | output | 4 | Current nesting depth |
| err_pulse | output | 1 | One-cycle flag for a bad completion or an overflow |

## Verification
A request and a completion can land on the same edge, and that is where the state update can go wrong. One case is an owner's nested read together with its own write completion, where the count must stay the same. Another is an owner's plain access together with a completion, where the release must win and no error may appear. A third is a completion with a bad ID next to a legal request. Directed cycles build each of these on purpose. Random cycles draw requests and completions independently from a small ID pool, which lands on the same combinations many times. Every cycle is judged against a bench model that applies the release rule first and then the net count change.

// File: rtl/asg_pkg.sv
package asg_pkg;
  localparam int unsigned KIND_W = 3;
  typedef logic [KIND_W-1:0] kind_t;

  localparam kind_t KIND_LOAD   = 3'd0;
  localparam kind_t KIND_STORE  = 3'd1;
  localparam kind_t KIND_RMW_RD = 3'd2;
  localparam kind_t KIND_RMW_WR = 3'd3;
  localparam kind_t KIND_FETCH  = 3'd4;

  // kinds that keep an atomic sequence alive when the owner sends them
  function automatic logic keeps_sequence(input kind_t k);
    return (k == KIND_RMW_RD) || (k == KIND_RMW_WR);
  endfunction

  function automatic logic opens_level(input kind_t k);
    return k == KIND_RMW_RD;
  endfunction
endpackage

// File: rtl/gate_admit.sv
module gate_admit
  import asg_pkg::*;
#(
  parameter int unsigned ID_W    = 8,
  parameter int unsigned FREE_ID = 200
) (
  input  logic [ID_W-1:0] owner_q,
  input  logic            req_valid,
  input  logic [ID_W-1:0] req_id,
  input  kind_t           req_type,
  input  logic            dont_set,
  output logic            ready,
  output logic            owned,
  output logic            open_lvl,
  output logic            drop_seq
);
  localparam logic [ID_W-1:0] FREE = FREE_ID[ID_W-1:0];

  logic accept;
  logic from_owner;

  always_comb begin
    owned      = (owner_q != FREE);
    from_owner = owned && (req_id == owner_q);
    ready      = !owned || from_owner;
    accept     = req_valid && ready && !dont_set;
    open_lvl   = accept && opens_level(req_type);
    drop_seq   = accept && from_owner && !keeps_sequence(req_type);
  end
endmodule

// File: rtl/gate_count.sv
module gate_count #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             ovf_evt,
  output logic             empty_next
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] cur,
                                            input logic up, input logic down);
    logic [CNT_W-1:0] r;
    r = cur;
    if (up && !down && cur != CNT_MAX) r = cur + CNT_W'(1);
    else if (down && !up)              r = cur - CNT_W'(1);
    return r;
  endfunction

  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d      = clr ? '0 : step(cnt_q, inc, dec);
    ovf_evt    = !clr && inc && !dec && (cnt_q == CNT_MAX);
    empty_next = (cnt_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && inc && !dec && !clr) |=> (cnt_q == CNT_MAX));

  // R7
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (cnt_q != '0));
endmodule

// File: rtl/gate_owner.sv
module gate_owner #(
  parameter int unsigned ID_W    = 8,
  parameter int unsigned FREE_ID = 200
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            claim,
  input  logic            vacate,
  input  logic [ID_W-1:0] req_id,
  output logic [ID_W-1:0] owner_q
);
  localparam logic [ID_W-1:0] FREE = FREE_ID[ID_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          owner_q <= FREE;
    else if (vacate)                     owner_q <= FREE;
    else if (claim && owner_q == FREE)   owner_q <= req_id;
  end

  // R3
  claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && !vacate && owner_q == FREE) |=> (owner_q == $past(req_id)));
endmodule

// File: rtl/atomic_seq_gate.sv
module atomic_seq_gate
  import asg_pkg::*;
#(
  parameter int unsigned ID_W    = 8,
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned FREE_ID = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [ID_W-1:0]  req_id,
  input  logic [2:0]       req_type,
  input  logic             req_dont_set,
  output logic             req_ready,
  input  logic             cmpl_valid,
  input  logic [ID_W-1:0]  cmpl_id,
  output logic [ID_W-1:0]  owner_id,
  output logic [CNT_W-1:0] nest_count,
  output logic             err_pulse
);
  localparam logic [ID_W-1:0] FREE = FREE_ID[ID_W-1:0];

  logic owned, open_lvl, drop_seq;
  logic cmpl_bad, cmpl_ok;
  logic ovf_evt, empty_next;
  logic err_q;

  gate_admit #(.ID_W(ID_W), .FREE_ID(FREE_ID)) u_admit (
    .owner_q  (owner_id),
    .req_valid(req_valid),
    .req_id   (req_id),
    .req_type (kind_t'(req_type)),
    .dont_set (req_dont_set),
    .ready    (req_ready),
    .owned    (owned),
    .open_lvl (open_lvl),
    .drop_seq (drop_seq)
  );

  always_comb begin
    cmpl_bad = cmpl_valid && (!owned || cmpl_id != owner_id || nest_count == '0);
    cmpl_ok  = cmpl_valid && !cmpl_bad;
  end

  gate_count #(.CNT_W(CNT_W)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .inc       (open_lvl),
    .dec       (cmpl_ok),
    .clr       (drop_seq),
    .cnt_q     (nest_count),
    .ovf_evt   (ovf_evt),
    .empty_next(empty_next)
  );

  gate_owner #(.ID_W(ID_W), .FREE_ID(FREE_ID)) u_owner (
    .clk    (clk),
    .rst_n  (rst_n),
    .claim  (open_lvl),
    .vacate (empty_next),
    .req_id (req_id),
    .owner_q(owner_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= cmpl_bad || ovf_evt;
  end
  assign err_pulse = err_q;

  // R5
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_seq |=> (owner_id == FREE && nest_count == '0));

  // R8
  probe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_dont_set && !cmpl_valid) |=> ($stable(owner_id) && $stable(nest_count)));

  // R7
  bad_cmpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_valid && (owner_id == FREE || cmpl_id != owner_id)) |=> err_pulse);

  // R6
  owner_count_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((nest_count == '0) == (owner_id == FREE)));

  // R2
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !cmpl_valid) |=> $stable(owner_id));
endmodule

// File: tb/test_atomic_seq_gate.sv
module test_atomic_seq_gate;
  localparam int CLK_PERIOD = 10;
  localparam int FREE = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [7:0] req_id = '0;
  logic [2:0] req_type = '0;
  logic       req_dont_set = 1'b0;
  logic       req_ready;
  logic       cmpl_valid = 1'b0;
  logic [7:0] cmpl_id = '0;
  logic [7:0] owner_id;
  logic [3:0] nest_count;
  logic       err_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  int m_owner = FREE;
  int m_cnt = 0;
  int m_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  atomic_seq_gate i_atomic_seq_gate (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_id(req_id), .req_type(req_type),
    .req_dont_set(req_dont_set), .req_ready(req_ready),
    .cmpl_valid(cmpl_valid), .cmpl_id(cmpl_id),
    .owner_id(owner_id), .nest_count(nest_count), .err_pulse(err_pulse)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model_ready(input int id);
    if (m_owner == FREE) return 1;
    return (id == m_owner) ? 1 : 0;
  endfunction

  function automatic string pick_tag(input int v, input int id, input int t,
                                     input int ds, input int cv, input int cid);
    int go;
    go = v && model_ready(id) && !ds;
    if (cv && !(m_owner != FREE && cid == m_owner && m_cnt > 0)) return "R7";
    if (go && t != 2 && t != 3 && m_owner != FREE) return "R5";
    if (go && t == 2 && cv) return "R11";
    if (go && t == 2 && m_cnt == 15) return "R9";
    if (go && t == 2 && m_owner == FREE) return "R3";
    if (go && t == 2) return "R4";
    if (cv) return "R6";
    if (v && ds) return "R8";
    return "R10";
  endfunction

  // advance the reference state by one clock edge
  task automatic model_step(input int v, input int id, input int t,
                            input int ds, input int cv, input int cid);
    int go, bad, up, down, ovf;
    go   = v && model_ready(id) && !ds;
    bad  = cv && !(m_owner != FREE && cid == m_owner && m_cnt > 0);
    up   = go && (t == 2);
    down = cv && !bad;
    ovf  = 0;
    if (go && t != 2 && t != 3 && m_owner != FREE) begin
      m_owner = FREE;
      m_cnt   = 0;
    end else begin
      if (up && !down) begin
        if (m_cnt == 15) ovf = 1;
        else begin
          if (m_owner == FREE) m_owner = id;
          m_cnt++;
        end
      end else if (down && !up) begin
        m_cnt--;
      end
      if (m_cnt == 0) m_owner = FREE;
    end
    m_err = (bad || ovf) ? 1 : 0;
  endtask

  // one cycle: drive at a falling edge, check ready, step, check state at next falling edge
  task automatic cyc(input int v, input int id, input int t, input int ds,
                     input int cv, input int cid, input string force_tag);
    string tag;
    int exp_rdy;
    tag = (force_tag != "") ? force_tag : pick_tag(v, id, t, ds, cv, cid);
    req_valid = v[0]; req_id = id[7:0]; req_type = t[2:0];
    req_dont_set = ds[0]; cmpl_valid = cv[0]; cmpl_id = cid[7:0];
    #1;
    exp_rdy = model_ready(id);
    chk("R2 ready", int'(req_ready), exp_rdy);
    model_step(v, id, t, ds, cv, cid);
    @(negedge clk);
    chk({tag, " owner"}, int'(owner_id), m_owner);
    chk({tag, " count"}, int'(nest_count), m_cnt);
    chk({tag, " error"}, int'(err_pulse), m_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 owner", int'(owner_id), FREE);
    chk("R1 count", int'(nest_count), 0);
    chk("R1 error", int'(err_pulse), 0);
    chk("R2 free ready", int'(req_ready), 1);

    cyc(1, 5, 2, 0, 0, 0, "R3");
    chk("R3 literal owner", int'(owner_id), 5);
    cyc(1, 9, 0, 0, 0, 0, "R2");
    chk("R2 refused ready", int'(req_ready), 0);
    cyc(1, 5, 2, 0, 0, 0, "R4");
    chk("R4 literal count", int'(nest_count), 2);
    cyc(1, 5, 2, 1, 0, 0, "R8");
    chk("R8 literal count", int'(nest_count), 2);
    cyc(0, 5, 0, 0, 1, 9, "R7");
    chk("R7 literal err", int'(err_pulse), 1);
    cyc(1, 5, 2, 0, 1, 5, "R11");
    chk("R11 literal count", int'(nest_count), 2);
    cyc(1, 5, 3, 0, 0, 0, "R10");
    cyc(0, 0, 0, 0, 1, 5, "R6");
    cyc(0, 0, 0, 0, 1, 5, "R6");
    chk("R6 literal owner", int'(owner_id), FREE);
    cyc(0, 0, 0, 0, 1, 5, "R7");
    chk("R7 literal err zero count", int'(err_pulse), 1);
    cyc(0, 0, 0, 0, 0, 0, "R7");
    chk("R7 err one cycle", int'(err_pulse), 0);
    for (int i = 0; i < 15; i++) cyc(1, 7, 2, 0, 0, 0, "");
    chk("R9 literal full", int'(nest_count), 15);
    cyc(1, 7, 2, 0, 0, 0, "R9");
    chk("R9 literal sat", int'(nest_count), 15);
    chk("R9 literal err", int'(err_pulse), 1);
    cyc(1, 7, 1, 0, 1, 7, "R5");
    chk("R5 literal owner", int'(owner_id), FREE);
    chk("R5 literal no err", int'(err_pulse), 0);

    for (int i = 0; i < 4000; i++) begin
      int v, id, t, ds, cv, cid, r;
      v   = ($urandom % 4 != 0) ? 1 : 0;
      id  = 1 + ($urandom % 3);
      r   = $urandom % 10;
      t   = (r < 5) ? 2 : (r < 7) ? 3 : ($urandom % 8);
      ds  = ($urandom % 8 == 0) ? 1 : 0;
      cv  = ($urandom % 3 == 0) ? 1 : 0;
      cid = ($urandom % 4 == 0) ? (1 + ($urandom % 3)) : m_owner;
      cyc(v, id, t, ds, cv, cid, "");
    end

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule